// File: doc/BRIEF.md
# Burst-Mode NOR Flash Read Controller

This block sits on the device side of a parallel NOR-style flash and owns the read path. It watches the active-low chip enable, output enable, write enable and address-valid strobes, the device reset, a clock, the address bus and the read configuration fields. From these it produces the word address presented to the storage array's synchronous read port, a data-valid indication that gates the data drivers, and a wait indicator.

One configuration bit picks the read mode. In asynchronous mode the array address follows the address pins, or holds a captured upper address while the four page bits keep following the pins. In synchronous mode a start address is captured on a clock edge and a programmable latency is counted. The controller then steps through a burst of 4, 8 or 16 words, or keeps going until it is stopped. The burst either runs linearly or wraps inside the aligned 16-word group that holds the start address. A burst into status or identifier space repeats one word instead of advancing.

The strobes are sampled on the clock. The address-valid strobe counts as a new pulse at the first clock edge that sees it low after it was high. Holding the device reset low returns the controller to idle.

Top module: `nor_read_ctrl`

## Requirements
- R1: `cfg_async` high selects asynchronous reads and keeps the burst sequencer idle (wait low). `cfg_async` low selects synchronous burst reads.
- R2: In asynchronous mode `data_valid` is high exactly while `ce_n` and `oe_n` are low and `we_n` is high. It follows these inputs without a clock.
- R3: In asynchronous mode, while `adv_n` is low, `arr_addr` equals `addr_in`. While `adv_n` is high, `arr_addr[AW-1:4]` holds the value `addr_in[AW-1:4]` had at the last clock edge that saw `adv_n` low.
- R4: In asynchronous mode `arr_addr[3:0]` always equals `addr_in[3:0]`, so each word of a 16-word page is chosen by the low bits alone.
- R5: In synchronous mode a start address is captured at a clock edge that sees `ce_n`, `oe_n` and `adv_n` low and `we_n` high, where `adv_n` was high at the previous edge. `wait_o` is high right after that edge.
- R6: After a capture edge, `data_valid` first rises after exactly L further clock edges. L is `cfg_latency`, and values 0 and 1 act as 2. `wait_o` stays high until then, and `wait_o` and `data_valid` are never high together.
- R7: During an array burst with `cfg_wrap` low, `arr_addr` rises by one at each clock edge, starting at the captured address.
- R8: When `id_space` is high at the capture edge, `arr_addr` holds the captured address for the whole burst.
- R9: When `cfg_wrap` is high at the capture edge, the burst address advances in bits [3:0] modulo 16 and bits [AW-1:4] stay at their captured value.
- R10: `cfg_burst_len` codes the burst length as 0=4, 1=8, 2=16 and 3=continuous words. After the last word of a finite burst, `data_valid` is low at the next edge.
- R11: `ce_n` high or `we_n` low at a clock edge sends a burst to idle, so `wait_o` and `data_valid` are low afterwards. A new `adv_n` low pulse during a burst restarts the latency with the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Device reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; must be high for reads |
| adv_n | input | 1 | Address valid strobe, active low |
| addr_in | input | AW | Word address pins |
| id_space | input | 1 | High selects status/identifier space (non-array) |
| cfg_async | input | 1 | Mode bit: 1 asynchronous, 0 synchronous burst |
| cfg_latency | input | 4 | Initial latency in clocks (values below 2 act as 2) |
| cfg_wrap | input | 1 | 1 wraps inside the 16-word group |
| cfg_burst_len | input | 2 | Burst length code |
| arr_addr | output | AW | Word address to the array read port |
| data_valid | output | 1 | Output word is valid, drivers enabled |
| wait_o | output | 1 | High while the latency count runs |

## Verification
Asynchronous reads are tried by holding the strobe low and then releasing it while the upper and lower address bits change separately. This separates a captured page address from the live page index. Bursts start at addresses just below a group boundary, with wrap on and off. The expected sequence then differs only in whether the upper bits roll over. Latencies of 0, 2, 3, 4 and 5 show whether the count runs one edge early or late, and whether the small-value clamp is applied. Identifier-space bursts, continuous bursts stopped by chip enable, and a burst cut short by a fresh strobe pulse show that the sequencer holds, stops and restarts as required.

// File: rtl/nrc_pkg.sv
package nrc_pkg;

  localparam int GRP_BITS = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LAT   = 2'd1,
    ST_BURST = 2'd2
  } bst_e;

  // latency field to clocks, small values clamped to the legal minimum
  function automatic logic [3:0] eff_latency(input logic [3:0] field);
    return (field < 4'd2) ? 4'd2 : field;
  endfunction

  // burst length code to word count (code 3 is continuous, not counted)
  function automatic logic [4:0] burst_words(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/nrc_async_addr.sv
module nrc_async_addr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] async_addr
);
  import nrc_pkg::*;

  localparam int UW = AW - GRP_BITS;

  logic [UW-1:0] page_q;

  // the upper address tracks the pins while the strobe is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      page_q <= '0;
    else if (!adv_n) page_q <= addr_in[AW-1:GRP_BITS];
  end

  // page index always comes straight from the pins
  always_comb begin
    if (!adv_n) async_addr = addr_in;
    else        async_addr = {page_q, addr_in[GRP_BITS-1:0]};
  end

endmodule

// File: rtl/nrc_burst_fsm.sv
module nrc_burst_fsm
  import nrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic       abort,
  input  logic [3:0] lat_field,
  input  logic [1:0] len_field,
  output bst_e       state,
  output logic       step,
  output logic       last
);

  bst_e       state_q;
  logic [3:0] cnt_q;
  logic [3:0] lat_q;
  logic [1:0] len_q;
  logic [4:0] idx_q;
  logic       lat_done;

  assign lat_done = (cnt_q + 4'd1) == lat_q;
  assign last     = (state_q == ST_BURST) && (len_q != 2'd3) &&
                    (idx_q == burst_words(len_q) - 5'd1);
  assign step     = (state_q == ST_BURST) && !last;
  assign state    = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lat_q   <= 4'd2;
      len_q   <= '0;
      idx_q   <= '0;
    end else if (capture) begin
      state_q <= ST_LAT;
      cnt_q   <= '0;
      idx_q   <= '0;
      lat_q   <= eff_latency(lat_field);
      len_q   <= len_field;
    end else if (abort) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_LAT: begin
          if (lat_done) begin
            state_q <= ST_BURST;
            idx_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 4'd1;
          end
        end
        ST_BURST: begin
          if (last)      state_q <= ST_IDLE;
          else if (step) idx_q   <= idx_q + 5'd1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nrc_burst_addr.sv
module nrc_burst_addr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          step,
  input  logic [AW-1:0] start_addr,
  input  logic          wrap_in,
  input  logic          id_in,
  output logic [AW-1:0] seq_addr,
  output logic          wrap_q,
  output logic          id_q
);
  import nrc_pkg::*;

  function automatic logic [AW-1:0] next_word(input logic [AW-1:0] a,
                                              input logic wrap,
                                              input logic id);
    logic [GRP_BITS-1:0] low;
    low = a[GRP_BITS-1:0] + 1'b1;
    if (id)        return a;
    else if (wrap) return {a[AW-1:GRP_BITS], low};
    else           return a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_addr <= '0;
      wrap_q   <= 1'b0;
      id_q     <= 1'b0;
    end else if (capture) begin
      seq_addr <= start_addr;
      wrap_q   <= wrap_in;
      id_q     <= id_in;
    end else if (step) begin
      seq_addr <= next_word(seq_addr, wrap_q, id_q);
    end
  end

endmodule

// File: rtl/nor_read_ctrl.sv
module nor_read_ctrl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr_in,
  input  logic          id_space,
  input  logic          cfg_async,
  input  logic [3:0]    cfg_latency,
  input  logic          cfg_wrap,
  input  logic [1:0]    cfg_burst_len,
  output logic [AW-1:0] arr_addr,
  output logic          data_valid,
  output logic          wait_o
);
  import nrc_pkg::*;

  logic          adv_prev;
  logic          read_ok;
  logic          capture_evt;
  logic          abort_evt;
  logic          step_evt;
  logic          last_evt;
  bst_e          bstate;
  logic [AW-1:0] async_addr;
  logic [AW-1:0] seq_addr;
  logic          wrap_q;
  logic          id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adv_prev <= 1'b1;
    else        adv_prev <= adv_n;
  end

  assign read_ok     = !ce_n && !oe_n && we_n;
  assign capture_evt = !cfg_async && read_ok && !adv_n && adv_prev;
  assign abort_evt   = cfg_async || ce_n || !we_n;

  nrc_async_addr #(.AW(AW)) u_async (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_n      (adv_n),
    .addr_in    (addr_in),
    .async_addr (async_addr)
  );

  nrc_burst_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture_evt),
    .abort     (abort_evt),
    .lat_field (cfg_latency),
    .len_field (cfg_burst_len),
    .state     (bstate),
    .step      (step_evt),
    .last      (last_evt)
  );

  nrc_burst_addr #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture_evt),
    .step       (step_evt),
    .start_addr (addr_in),
    .wrap_in    (cfg_wrap),
    .id_in      (id_space),
    .seq_addr   (seq_addr),
    .wrap_q     (wrap_q),
    .id_q       (id_q)
  );

  assign wait_o     = (bstate == ST_LAT);
  assign data_valid = cfg_async ? read_ok : (read_ok && bstate == ST_BURST);
  assign arr_addr   = cfg_async ? async_addr : seq_addr;

endmodule

// File: rtl/nrc_checker.sv
module nrc_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_async,
  input logic          ce_n,
  input logic          capture_evt,
  input logic          step_evt,
  input logic          wrap_q,
  input logic          id_q,
  input logic [AW-1:0] seq_addr,
  input logic          wait_o,
  input logic          data_valid
);

  assert_wait_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> !data_valid);

  assert_capture_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> wait_o);

  assert_async_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_async |=> !wait_o);

  assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !id_q && !wrap_q && !capture_evt) |=> seq_addr == $past(seq_addr) + 1'b1);

  assert_id_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && id_q && !capture_evt) |=> $stable(seq_addr));

  assert_wrap_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && wrap_q && !id_q && !capture_evt) |=>
      seq_addr[AW-1:4] == $past(seq_addr[AW-1:4]));

  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !capture_evt) |=> !wait_o);

endmodule

bind nor_read_ctrl nrc_checker #(.AW(AW)) u_nrc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_async   (cfg_async),
  .ce_n        (ce_n),
  .capture_evt (capture_evt),
  .step_evt    (step_evt),
  .wrap_q      (wrap_q),
  .id_q        (id_q),
  .seq_addr    (seq_addr),
  .wait_o      (wait_o),
  .data_valid  (data_valid)
);

// File: tb/test_nor_read_ctrl.sv
module test_nor_read_ctrl;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n, adv_n;
  logic [AW-1:0] addr_in;
  logic          id_space;
  logic          cfg_async;
  logic [3:0]    cfg_latency;
  logic          cfg_wrap;
  logic [1:0]    cfg_burst_len;
  logic [AW-1:0] arr_addr;
  logic          data_valid;
  logic          wait_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nor_read_ctrl #(.AW(AW)) i_nor_read_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .adv_n(adv_n), .addr_in(addr_in), .id_space(id_space),
    .cfg_async(cfg_async), .cfg_latency(cfg_latency), .cfg_wrap(cfg_wrap),
    .cfg_burst_len(cfg_burst_len), .arr_addr(arr_addr),
    .data_valid(data_valid), .wait_o(wait_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected burst word, restated from R7/R8/R9
  function automatic logic [AW-1:0] exp_word(input logic [AW-1:0] s, input int w,
                                             input bit wrap, input bit id);
    logic [AW-1:0] lin;
    lin = s + AW'(w);
    if (id)        return s;
    else if (wrap) return {s[AW-1:4], lin[3:0]};
    else           return lin;
  endfunction

  task automatic launch(input logic [AW-1:0] s, input logic [3:0] lat,
                        input logic [1:0] len, input bit wrap, input bit id);
    cfg_async = 1'b0; cfg_latency = lat; cfg_burst_len = len; cfg_wrap = wrap;
    id_space = id; addr_in = s; ce_n = 0; oe_n = 0; adv_n = 0;
    @(posedge clk);
    @(negedge clk);
    adv_n = 1; addr_in = 16'hFFFF; id_space = 0; #1;
  endtask

  task automatic follow(input logic [AW-1:0] s, input int lat, input int n,
                        input bit wrap, input bit id, input bit finite);
    for (int k = 0; k < lat; k++) begin
      check("R5/R6 wait during latency", wait_o, 1);
      check("R6 no data during latency", data_valid, 0);
      tick(); #1;
    end
    for (int w = 0; w < n; w++) begin
      check("R6 data valid in burst", data_valid, 1);
      check("R6 wait low in burst", wait_o, 0);
      check(id ? "R8 repeated word" : (wrap ? "R9 wrapped word" : "R7 linear word"),
            arr_addr, exp_word(s, w, wrap, id));
      tick(); #1;
    end
    if (finite) check("R10 idle after last word", data_valid, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; adv_n = 1; addr_in = '0;
    id_space = 0; cfg_async = 0; cfg_latency = 4'd2; cfg_wrap = 0; cfg_burst_len = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset wait low", wait_o, 0);
    check("R1 reset valid low", data_valid, 0);
    rst_n = 1;
    tick();
  endtask

  task automatic t_async();
    cfg_async = 1; ce_n = 0; oe_n = 0; adv_n = 0; addr_in = 16'h1234; #1;
    check("R2 async valid", data_valid, 1);
    check("R3 async follows pins", arr_addr, 16'h1234);
    check("R1 async no wait", wait_o, 0);
    tick();
    adv_n = 1; addr_in = 16'h5678; #1;
    check("R3/R4 held page, live index", arr_addr, 16'h1238);
    addr_in = 16'h567B; #1;
    check("R4 page index follows", arr_addr, 16'h123B);
    tick(); #1;
    check("R3 page held across edges", arr_addr, 16'h123B);
    we_n = 0; #1;
    check("R2 write enable blocks read", data_valid, 0);
    we_n = 1; oe_n = 1; #1;
    check("R2 output enable high", data_valid, 0);
    oe_n = 0; ce_n = 1; #1;
    check("R2 chip enable high", data_valid, 0);
    ce_n = 0; #1;
    check("R2 valid again", data_valid, 1);
    ce_n = 1; tick();
  endtask

  task automatic t_burst(input logic [AW-1:0] s, input logic [3:0] latf, input int lat,
                         input logic [1:0] len, input int n, input bit wrap, input bit id);
    launch(s, latf, len, wrap, id);
    follow(s, lat, n, wrap, id, 1);
    ce_n = 1; tick();
  endtask

  task automatic t_continuous();
    launch(16'h03F8, 4'd2, 2'd3, 0, 0);
    follow(16'h03F8, 2, 20, 0, 0, 0);
    check("R10 continuous still valid", data_valid, 1);
    ce_n = 1; tick();
    ce_n = 0; #1;
    check("R11 chip enable abort data", data_valid, 0);
    check("R11 chip enable abort wait", wait_o, 0);
    ce_n = 1; tick();
  endtask

  task automatic t_we_abort();
    launch(16'h0500, 4'd2, 2'd3, 0, 0);
    follow(16'h0500, 2, 3, 0, 0, 0);
    we_n = 0; tick(); we_n = 1; #1;
    check("R11 write enable abort", data_valid, 0);
    ce_n = 1; tick();
  endtask

  task automatic t_restart();
    launch(16'h0040, 4'd3, 2'd3, 0, 0);
    follow(16'h0040, 3, 2, 0, 0, 0);
    launch(16'h0080, 4'd2, 2'd0, 0, 0);
    check("R11 restart wait", wait_o, 1);
    follow(16'h0080, 2, 4, 0, 0, 1);
    ce_n = 1; tick();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_async();
    t_burst(16'h000E, 4'd3, 3, 2'd0, 4, 1, 0);   // R9 wrap within group
    t_burst(16'h001E, 4'd4, 4, 2'd1, 8, 0, 0);   // R7 linear across group
    t_burst(16'h0125, 4'd2, 2, 2'd2, 16, 1, 0);  // R10 sixteen words, R9
    t_burst(16'h0077, 4'd5, 5, 2'd0, 4, 0, 1);   // R8 identifier space
    t_burst(16'h0200, 4'd0, 2, 2'd0, 4, 0, 0);   // R6 clamp to 2
    t_continuous();
    t_we_abort();
    t_restart();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule